// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two W-bit integers with a single ripple adder and reports four condition flags: signed overflow (V), negative (N), zero (Z) and carry (C). Subtraction reuses the adder. The subtrahend is bit-inverted, and the same control bit that drives the inversion also feeds the adder's carry input. The same hardware serves signed and unsigned operands. C reports unsigned overflow and V reports signed overflow, so no signedness input is needed.

The flags are held in a status register that loads only when an operation strobe is present. This lets a value wider than W bits be processed one word per operation, starting with the least significant word. The first word uses a plain add or subtract. Each higher word uses add-with-carry or subtract-with-carry, which take the stored C as their carry input. Only the V produced by the last, most significant word is meaningful for the wide signed result.

A configuration input selects what C means after a subtraction. It can signal "no borrow" (the raw adder carry-out) or "borrow" (the inverted carry-out). In borrow mode, subtract-with-carry inverts the stored C back before it reaches the adder.

Top module: `addsub_flags_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (a + b) mod 2^W. After the strobed cycle, flag_c equals the carry out of bit W-1.
- R2: With op_sel = 2'b01 (subtract), result equals (a - b) mod 2^W. This is computed as a + ~b + 1.
- R3: After a strobed operation, flag_v is 1 exactly when the two operands seen by the adder (a, and b or ~b) have the same sign and the result sign differs from it.
- R4: After a strobed operation, flag_n equals bit W-1 of that operation's result.
- R5: After a strobed operation, flag_z is 1 only when every bit of that operation's result is 0.
- R6: With borrow_mode = 0, flag_c after a subtract or subtract-with-carry is the raw adder carry-out. For plain subtract this is 1 exactly when a >= b (unsigned).
- R7: With borrow_mode = 1, flag_c after a subtract or subtract-with-carry is the inverse of the adder carry-out. For plain subtract this is 1 exactly when a < b (unsigned).
- R8: With op_sel = 2'b10 (add-with-carry), the adder carry input is the stored flag_c. With op_sel = 2'b11 (subtract-with-carry), the carry input is flag_c when borrow_mode = 0 and its inverse when borrow_mode = 1.
- R9: When op_valid is 0, the four flags keep their values while the result output still follows the inputs.
- R10: A synchronous reset (rst = 1 at a rising edge) clears all four flags to 0. It overrides op_valid.
- R11: A 2W-bit add or subtract done as a plain operation on the low word followed by the carry form on the high word gives the 2W-bit wrapped sum or difference. The final flag_v gives the 2W-bit signed overflow, in both borrow modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears flags |
| op_valid | input | 1 | Strobe: load the flags from this cycle's operation |
| op_sel | input | 2 | 00 add, 01 subtract, 10 add-with-carry, 11 subtract-with-carry |
| borrow_mode | input | 1 | 1: C after subtraction means borrow occurred |
| a | input | W | First operand (minuend) |
| b | input | W | Second operand (subtrahend) |
| result | output | W | Combinational sum or difference |
| flag_v | output | 1 | Stored signed overflow |
| flag_n | output | 1 | Stored negative |
| flag_z | output | 1 | Stored zero |
| flag_c | output | 1 | Stored carry or borrow |

## Verification
The bench aims at the signed boundary from both sides: 0x7F plus 1, 0x80 minus 1, 0x80 plus 0x80, and 0 minus 0x80. A design that took V from the raw carry would flag these wrongly, and one that checked only the upward crossing would miss the subtract cases.

Subtraction of equal values and of zero checks both the zero flag and the C sense in each borrow mode. A design with the borrow inversion on the wrong side would report the opposite C on exactly these operands.

Chained 16-bit sums and differences, run in both modes and with an operation-free gap between the words, show whether subtract-with-carry re-inverts the stored C. They also show whether a missing strobe really holds the flag state. A wrong choice here drifts the upper word by one.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_ADC = 2'b10,
    OP_SBC = 2'b11
  } op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  // Carry input of the least significant adder stage.
  function automatic logic pick_cin(op_e op, logic borrow_mode, logic c_held);
    logic r;
    case (op)
      OP_ADD:  r = 1'b0;
      OP_SUB:  r = 1'b1;
      OP_ADC:  r = c_held;
      default: r = borrow_mode ? ~c_held : c_held;
    endcase
    return r;
  endfunction

  // Value written to the stored C from the adder carry-out.
  function automatic logic c_report(logic is_sub, logic borrow_mode, logic cout);
    return (is_sub & borrow_mode) ? ~cout : cout;
  endfunction

endpackage

// File: rtl/addsub_opnd.sv
module addsub_opnd
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic         borrow_mode,
  input  logic         c_held,
  input  logic [W-1:0] b,
  output logic [W-1:0] b_eff,
  output logic         cin
);
  logic invert;

  // op bit 0 marks the subtract forms; it drives the XOR inversion
  assign invert = op[0];
  assign b_eff  = b ^ {W{invert}};
  assign cin    = pick_cin(op, borrow_mode, c_held);
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] cy;

  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = x[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
  end

  assign c_into_msb = cy[W-1];
  assign c_out      = cy[W];
endmodule

// File: rtl/addsub_flagcalc.sv
module addsub_flagcalc
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum,
  input  logic         c_into_msb,
  input  logic         c_out,
  input  logic         is_sub,
  input  logic         borrow_mode,
  output flags_t       nxt
);
  always_comb begin
    nxt.v = c_into_msb ^ c_out;
    nxt.n = sum[W-1];
    nxt.z = ~|sum;
    nxt.c = c_report(is_sub, borrow_mode, c_out);
  end
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [1:0]   op_sel,
  input  logic         borrow_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag_v,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c
);
  op_e          op;
  flags_t       flags_q;
  flags_t       flags_d;
  logic [W-1:0] b_eff;
  logic         cin;
  logic         c_into_msb;
  logic         c_out;
  logic [W:0]   add_wide;

  assign op = op_e'(op_sel);

  addsub_opnd #(.W(W)) u_opnd (
    .op(op), .borrow_mode(borrow_mode), .c_held(flags_q.c),
    .b(b), .b_eff(b_eff), .cin(cin)
  );

  addsub_ripple #(.W(W)) u_add (
    .x(a), .y(b_eff), .cin(cin), .sum(result),
    .c_into_msb(c_into_msb), .c_out(c_out)
  );

  addsub_flagcalc #(.W(W)) u_flags (
    .sum(result), .c_into_msb(c_into_msb), .c_out(c_out),
    .is_sub(op_sel[0]), .borrow_mode(borrow_mode), .nxt(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst)           flags_q <= '0;
    else if (op_valid) flags_q <= flags_d;
  end

  assign flag_v = flags_q.v;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;

  // Unsigned reference sum used only by the carry check below
  assign add_wide = {1'b0, a} + {1'b0, b};

  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_ADD) |=> flag_c == $past(add_wide[W]));

  a_r3_overflow: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_v == $past((a[W-1] == b_eff[W-1]) && (result[W-1] != a[W-1])));

  a_r4_negative: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_n == $past(result[W-1]));

  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_z == $past(result == '0));

  // R6 and R7: carry sense of a plain subtract in both modes
  a_r7_sub_sense: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SUB) |=> flag_c == $past(borrow_mode ^ (a >= b)));

  a_r8_adc_cin: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADC) |-> cin == flag_c);

  a_r8_sbc_cin: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SBC) |-> cin == (flag_c ^ borrow_mode));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(flag_v) && $stable(flag_n) && $stable(flag_z) && $stable(flag_c)));

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!flag_v && !flag_n && !flag_z && !flag_c));
endmodule

// File: tb/tb_addsub_flags_unit.sv
`timescale 1ns/1ps
module tb_addsub_flags_unit;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 0, rst = 1, op_valid = 0, borrow_mode = 0;
  logic [1:0] op_sel = 0;
  logic [W-1:0] a = 0, b = 0;
  logic [W-1:0] result;
  logic flag_v, flag_n, flag_z, flag_c;

  int nchk = 0, nfail = 0;
  int rv = 0, rn = 0, rz = 0, rc = 0;
  int last_res = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addsub_flags_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .borrow_mode(borrow_mode), .a(a), .b(b), .result(result),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic check_flags(input string ctag);
    chk("R3 flag_v", flag_v, rv);
    chk("R4 flag_n", flag_n, rn);
    chk("R5 flag_z", flag_z, rz);
    chk(ctag, flag_c, rc);
  endtask

  task automatic run_op(input int op, input int mode, input int x, input int y, input int vld);
    int sub, cin, yb, ures, eres, cout, sx, sy, ss, ev;
    string rtag, ctag;
    @(negedge clk);
    op_sel = op[1:0]; borrow_mode = mode[0]; a = x[W-1:0]; b = y[W-1:0]; op_valid = vld[0];
    sub = op % 2;
    case (op)
      0: cin = 0;
      1: cin = 1;
      2: cin = rc;
      default: cin = mode ? 1 - rc : rc;
    endcase
    yb   = sub ? (M - 1 - y) : y;
    ures = x + yb + cin;
    eres = ures % M;
    cout = ures / M;
    sx = (x >= M/2) ? x - M : x;
    sy = (yb >= M/2) ? yb - M : yb;
    ss = sx + sy + cin;
    ev = (ss > M/2 - 1 || ss < -(M/2)) ? 1 : 0;
    rtag = (op >= 2) ? "R8 result" : (sub ? "R2 result" : "R1 result");
    #1;
    chk(rtag, result, eres);
    last_res = result;
    @(posedge clk); #1;
    if (vld != 0) begin
      rv = ev; rn = eres / (M/2); rz = (eres == 0); rc = (sub && mode) ? 1 - cout : cout;
      ctag = sub ? (mode ? "R7 flag_c" : "R6 flag_c") : "R1 flag_c";
      check_flags(ctag);
    end else begin
      check_flags("R9 flag_c held");
    end
  endtask

  task automatic wide(input int is_sub, input int mode, input int x, input int y, input int gap);
    int lo, hi, exp, sx, sy, ss;
    run_op(is_sub, mode, x % M, y % M, 1);
    lo = last_res;
    if (gap != 0) run_op(0, mode, 5, 9, 0);
    run_op(2 + is_sub, mode, x / M, y / M, 1);
    hi = last_res;
    exp = is_sub ? (x - y + M*M) % (M*M) : (x + y) % (M*M);
    chk("R11 wide result", hi * M + lo, exp);
    sx = (x >= M*M/2) ? x - M*M : x;
    sy = (y >= M*M/2) ? y - M*M : y;
    ss = is_sub ? sx - sy : sx + sy;
    chk("R11 wide flag_v", flag_v, (ss > M*M/2 - 1 || ss < -(M*M/2)) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset v", flag_v, 0); chk("R10 reset n", flag_n, 0);
    chk("R10 reset z", flag_z, 0); chk("R10 reset c", flag_c, 0);
    @(negedge clk); rst = 0;

    // boundary cases
    run_op(0, 0, 8'h7F, 8'h01, 1);   // signed overflow upward
    run_op(0, 0, 8'h80, 8'h80, 1);   // overflow, carry, zero
    run_op(0, 0, 8'hFF, 8'h01, 1);   // carry, zero, no V
    run_op(1, 0, 8'h80, 8'h01, 1);   // signed overflow downward
    run_op(1, 0, 8'h00, 8'h80, 1);   // 0 - min overflows
    run_op(1, 0, 8'h33, 8'h33, 1);   // equal: zero, no borrow
    run_op(1, 1, 8'h33, 8'h33, 1);
    run_op(1, 0, 8'h00, 8'h01, 1);   // borrow
    run_op(1, 1, 8'h00, 8'h01, 1);
    run_op(1, 1, 8'h05, 8'h00, 1);
    // carry forms after known C
    run_op(0, 0, 8'hF0, 8'h20, 1);   // C=1
    run_op(2, 0, 8'h01, 8'h01, 1);   // R8 adds the carry
    run_op(1, 1, 8'h01, 8'h02, 1);   // borrow flagged C=1
    run_op(3, 1, 8'h10, 8'h01, 1);   // R8 cin = ~C = 0
    run_op(3, 0, 8'h10, 8'h01, 1);
    // strobe low: flags hold (R9)
    run_op(0, 0, 8'h7F, 8'h7F, 0);
    run_op(1, 1, 8'h00, 8'h00, 0);

    // R11 chains
    wide(0, 0, 16'h00FF, 16'h0001, 0);
    wide(0, 0, 16'h7FFF, 16'h0001, 0);
    wide(1, 0, 16'h0100, 16'h0001, 0);
    wide(1, 1, 16'h0100, 16'h0001, 1);
    wide(1, 1, 16'h8000, 16'h0001, 0);
    wide(1, 0, 16'h1234, 16'h1234, 1);
    wide(0, 1, 16'h8000, 16'h8000, 0);

    // R10 reset overriding a strobe
    @(negedge clk); rst = 1; op_valid = 1; op_sel = 0; a = 8'hFF; b = 8'hFF;
    @(posedge clk); #1;
    rv = 0; rn = 0; rz = 0; rc = 0;
    check_flags("R10 flag_c");
    @(negedge clk); rst = 0; op_valid = 0;

    for (int i = 0; i < 400; i++) begin
      int op, md, vl, rx, ry;
      op = $urandom % 4; md = $urandom % 2; vl = ($urandom % 4) != 0;
      rx = $urandom % M; ry = $urandom % M;
      run_op(op, md, rx, ry, vl);
    end
    for (int i = 0; i < 40; i++) begin
      int wx, wy;
      wx = $urandom % (M*M); wy = $urandom % (M*M);
      wide(i % 2, (i / 2) % 2, wx, wy, (i / 4) % 2);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule